// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block takes charge of an asynchronous DRAM from reset onward. First it holds every strobe inactive through a power-up pause. Then it runs a fixed number of dummy RAS-only cycles to initialise the memory, and only after that raises a ready flag. In normal operation an interval timer counts out the average per-row refresh period. At each expiry the timer adds one entry to a small count of pending refreshes.

While any refresh is pending the block raises a request to the bus arbiter. When the grant arrives, which means the access sequencer is idle, the block drives a CAS-before-RAS refresh cycle. In that cycle CAS falls first, RAS follows while CAS stays low, RAS is held for the minimum active time, and the bus is kept for the precharge time before it is returned. No address is driven, because the memory takes the refresh row from its own counter. Write enable and output enable stay inactive throughout, so the data bus stays high-impedance.

Refreshes can be postponed while the grant is withheld. The pending count then drains in back-to-back cycles once the grant returns. Timing values are parameters: the clock frequency is given in MHz, and the pause and refresh interval are derived from it as cycle counts.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, no RAS pulse starts before PWRUP_US × CLK_MHZ clock cycles have passed.
- R2: Before ready is raised, exactly INIT_CYC RAS pulses are issued, and CAS stays high (inactive) during every one of them.
- R3: `ready_o` rises no earlier than TRP_CYC cycles after the rising edge of the last initialisation RAS pulse.
- R4: Once ready, every RAS falling edge finds CAS already low, and CAS was also low in the previous cycle.
- R5: Every RAS low pulse, whether initialisation or refresh, lasts at least TRAS_CYC cycles.
- R6: After a refresh, RAS stays high for at least TRP_CYC cycles before `busy_o` falls.
- R7: `we_n_o` and `oe_n_o` are high (inactive, value 1) at all times.
- R8: `busy_o` is high from reset until ready and throughout each refresh. While `busy_o` is low, `ras_n_o` and `cas_n_o` are both 1.
- R9: After ready, a refresh cycle (`busy_o` rising) starts only when both `req_o` and `gnt_i` were high in the preceding cycle. With `gnt_i` low, no refresh starts.
- R10: Once ready, one refresh becomes due every REFI_NS × CLK_MHZ / 1000 cycles. With the grant available, the number of refreshes performed equals the number of intervals elapsed since ready.
- R11: Due refreshes accumulate while the grant is withheld. `req_o` stays high until every one of them is performed, the backlog is served back to back once the grant returns, and the pending count never exceeds PEND_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus grant; high when the access sequencer is idle and yields the bus |
| req_o | output | 1 | Refresh request; high while any refresh is pending |
| ready_o | output | 1 | High once power-up and initialisation are complete |
| busy_o | output | 1 | High while the block owns the DRAM strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held inactive |
| oe_n_o | output | 1 | Output enable, active low, held inactive |

## Verification
The hardest case to reach is a backlog of several pending refreshes served back to back. This needs the grant withheld across more than one interval boundary, with the start of the withheld window placed at a known phase of the hidden interval timer. The stimulus takes that phase from the cycle at which `ready_o` rises. It parks the grant low for exactly three intervals, starting at mid-interval with nothing pending, then restores the grant and counts the CAS-before-RAS edges. Random grant on/off phases from a fixed seed come first and run throughout. Each random withheld window is bounded so that the pending count stays within its limit.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP, // power-up pause
    ST_IRAS,  // init: RAS low
    ST_IPRE,  // init: precharge
    ST_IDLE,
    ST_CSR,   // refresh: CAS low ahead of RAS
    ST_RAS,   // refresh: CAS and RAS low
    ST_PRE    // refresh: precharge before release
  } ref_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int REFI_CYC = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(REFI_CYC);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == W'(REFI_CYC - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r10_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr #(
  parameter int PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic req_o
);
  // one spare bit so an overrun is visible rather than wrapped
  localparam int PW = $clog2(PEND_MAX + 2);

  logic [PW-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= '0;
    else if (inc_i && !dec_i)  pend_q <= pend_q + 1'b1;
    else if (dec_i && !inc_i)  pend_q <= pend_q - 1'b1;
  end

  assign req_o = (pend_q != '0);

  a_r11_pend_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PW'(PEND_MAX));
  a_r11_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> pend_q != '0);
endmodule

// File: rtl/ref_strobe_fsm.sv
module ref_strobe_fsm
  import dram_ref_pkg::*;
#(
  parameter int PWRUP_CYC = 20000,
  parameter int TRAS_CYC  = 6,
  parameter int TRP_CYC   = 4,
  parameter int TCSR_CYC  = 2,
  parameter int INIT_CYC  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic gnt_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic ready_o,
  output logic done_o
);
  localparam int CW = $clog2(PWRUP_CYC + TRAS_CYC + TRP_CYC + TCSR_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  ref_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          ready_q, ready_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    init_d  = init_q;
    ready_d = ready_q;
    done_o  = 1'b0;
    unique case (state_q)
      ST_PWRUP: if (cnt_q == CW'(PWRUP_CYC - 1)) begin
        state_d = ST_IRAS; cnt_d = '0;
      end
      ST_IRAS: if (cnt_q == CW'(TRAS_CYC - 1)) begin
        state_d = ST_IPRE; cnt_d = '0;
      end
      ST_IPRE: if (cnt_q == CW'(TRP_CYC - 1)) begin
        cnt_d = '0;
        if (init_q == IW'(INIT_CYC - 1)) begin
          state_d = ST_IDLE; ready_d = 1'b1;
        end else begin
          state_d = ST_IRAS; init_d = init_q + 1'b1;
        end
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (req_i && gnt_i) state_d = ST_CSR;
      end
      ST_CSR: if (cnt_q == CW'(TCSR_CYC - 1)) begin
        state_d = ST_RAS; cnt_d = '0;
      end
      ST_RAS: if (cnt_q == CW'(TRAS_CYC - 1)) begin
        state_d = ST_PRE; cnt_d = '0;
      end
      ST_PRE: if (cnt_q == CW'(TRP_CYC - 1)) begin
        state_d = ST_IDLE; cnt_d = '0; done_o = 1'b1;
      end
      default: begin
        state_d = ST_IDLE; cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      cnt_q   <= '0;
      init_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      ready_q <= ready_d;
    end
  end

  assign ras_n_o = !(state_q == ST_IRAS || state_q == ST_RAS);
  assign cas_n_o = !(state_q == ST_CSR  || state_q == ST_RAS);
  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = ready_q;

  // checker state: RAS low width and pre-ready RAS fall count
  logic [CW-1:0] chk_lo_q;
  logic [IW:0]   chk_falls_q;
  logic          chk_ras_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_lo_q    <= '0;
      chk_falls_q <= '0;
      chk_ras_q   <= 1'b1;
    end else begin
      chk_ras_q <= ras_n_o;
      chk_lo_q  <= ras_n_o ? '0 : chk_lo_q + 1'b1;
      if (chk_ras_q && !ras_n_o && !ready_q && chk_falls_q != '1)
        chk_falls_q <= chk_falls_q + 1'b1;
    end
  end

  a_r5_tras_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> chk_lo_q >= CW'(TRAS_CYC));
  a_r2_ready_after_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> chk_falls_q == (IW+1)'(INIT_CYC));
  a_r4_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $fell(ras_n_o)) |-> (!cas_n_o && $past(!cas_n_o)));
  a_r9_start_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $rose(busy_o)) |-> $past(gnt_i && req_i));
  a_r8_idle_strobes_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (ras_n_o && cas_n_o && $past(ras_n_o)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_MHZ  = 100,
  parameter int PWRUP_US = 200,
  parameter int REFI_NS  = 15625,
  parameter int TRAS_CYC = 6,
  parameter int TRP_CYC  = 4,
  parameter int TCSR_CYC = 2,
  parameter int INIT_CYC = 8,
  parameter int PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  output logic req_o,
  output logic ready_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic oe_n_o
);
  localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
  localparam int REFI_CYC  = (REFI_NS * CLK_MHZ) / 1000;

  logic tick, done;

  ref_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk_i, .rst_ni, .en_i(ready_o), .tick_o(tick)
  );

  ref_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk_i, .rst_ni, .inc_i(tick), .dec_i(done), .req_o
  );

  ref_strobe_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .TRAS_CYC(TRAS_CYC), .TRP_CYC(TRP_CYC),
    .TCSR_CYC(TCSR_CYC), .INIT_CYC(INIT_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .req_i(req_o), .gnt_i,
    .ras_n_o, .cas_n_o, .busy_o, .ready_o, .done_o(done)
  );

  // refresh and init cycles never write or drive data
  assign we_n_o = 1'b1;
  assign oe_n_o = 1'b1;
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ  = 10;
  localparam int PWRUP_US = 200;
  localparam int REFI_NS  = 15625;
  localparam int TRAS     = 4;
  localparam int TRP      = 3;
  localparam int TCSR     = 2;
  localparam int NINIT    = 8;
  localparam int PMAX     = 4;
  localparam int PWRUP    = PWRUP_US * CLK_MHZ;
  localparam int REFI     = (REFI_NS * CLK_MHZ) / 1000;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic req, ready, busy, ras_n, cas_n, we_n, oe_n;

  int checks = 0, fails = 0;
  int cyc = 0;
  int ready_cyc = -1;
  int init_falls = 0, refreshes = 0;
  int low_w = 0, last_rise = 0;
  bit seen_fall = 1'b0, fin = 1'b0;
  logic ras_p = 1'b1, cas_p = 1'b1, busy_p = 1'b1, ready_p = 1'b0;
  logic gnt_p = 1'b0, req_p = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .REFI_NS(REFI_NS),
    .TRAS_CYC(TRAS), .TRP_CYC(TRP), .TCSR_CYC(TCSR),
    .INIT_CYC(NINIT), .PEND_MAX(PMAX)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req), .ready_o(ready),
    .busy_o(busy), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .oe_n_o(oe_n)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req_tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_refreshes(input int now);
    return (now - ready_cyc) / REFI;
  endfunction

  // port monitor, sampled away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(we_n && oe_n, "R7 we/oe inactive", {we_n, oe_n}, 3);
    if (!busy) chk(ras_n && cas_n, "R8 strobes off when not busy", {ras_n, cas_n}, 3);
    if (!ready) chk(busy, "R8 busy during startup", busy, 1);
    if (!ras_n) low_w++;
    if (ras_p && !ras_n) begin
      if (!seen_fall) begin
        seen_fall = 1'b1;
        chk(cyc >= PWRUP, "R1 power-up pause", cyc, PWRUP);
      end
      if (!ready) begin
        init_falls++;
        chk(cas_n, "R2 init cycle CAS inactive", cas_n, 1);
      end else begin
        refreshes++;
        chk(!cas_n && !cas_p, "R4 CAS before RAS", {cas_p, cas_n}, 0);
      end
    end
    if (!ras_p && ras_n) begin
      chk(low_w >= TRAS, "R5 RAS low width", low_w, TRAS);
      low_w = 0;
      last_rise = cyc;
    end
    if (!ready_p && ready) begin
      ready_cyc = cyc;
      chk(init_falls == NINIT, "R2 init pulse count", init_falls, NINIT);
      chk(cyc - last_rise >= TRP, "R3 ready after precharge", cyc - last_rise, TRP);
    end
    if (ready_p && busy_p && !busy)
      chk(cyc - last_rise >= TRP, "R6 precharge before release", cyc - last_rise, TRP);
    if (ready_p && !busy_p && busy)
      chk(gnt_p && req_p, "R9 start needs req and gnt", {req_p, gnt_p}, 3);
    ras_p = ras_n; cas_p = cas_n; busy_p = busy; ready_p = ready;
    gnt_p = gnt; req_p = req;
  end

  task automatic drive_gnt(input logic v);
    @(posedge clk); #1 gnt = v;
  endtask

  task automatic align_mid();
    do @(negedge clk); while (((cyc - ready_cyc) % REFI) != REFI/2);
  endtask

  initial begin : main
    int r0;
    void'($urandom(32'h5eed_0d1a));
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R8 reset strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!ready && !req && busy, "R8 reset flags", {ready, req, busy}, 1);
    @(negedge clk) rst_n = 1'b1;
    wait (ready_cyc >= 0);
    drive_gnt(1'b1);

    // random grant phases; off windows bounded to keep backlog within PMAX
    for (int i = 0; i < 14; i++) begin
      drive_gnt(1'b1);
      repeat ($urandom_range(40, 250)) @(posedge clk);
      drive_gnt(1'b0);
      r0 = refreshes;
      repeat ($urandom_range(10, 2*REFI)) @(posedge clk);
      @(negedge clk);
      chk(refreshes - r0 <= 1, "R9 no refresh while gnt low", refreshes - r0, 1);
    end

    drive_gnt(1'b1);
    repeat (REFI) @(posedge clk);
    align_mid();
    chk(refreshes == exp_refreshes(cyc), "R10 refresh count", refreshes, exp_refreshes(cyc));
    chk(!req && !busy, "R11 nothing pending", {req, busy}, 0);

    // directed backlog of three
    drive_gnt(1'b0);
    r0 = refreshes;
    repeat (3*REFI - 1) @(posedge clk);
    @(negedge clk);
    chk(refreshes == r0, "R9 none while withheld", refreshes - r0, 0);
    chk(req, "R11 request held", req, 1);
    drive_gnt(1'b1);
    repeat (3*(TCSR+TRAS+TRP) + 6) @(posedge clk);
    @(negedge clk);
    chk(refreshes - r0 == 3, "R11 backlog drained", refreshes - r0, 3);
    chk(!req, "R11 request cleared", req, 0);

    repeat (2*REFI) @(posedge clk);
    align_mid();
    chk(refreshes == exp_refreshes(cyc), "R10 final count", refreshes, exp_refreshes(cyc));

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule